// File: doc/BRIEF.md
# Two-Phase Parallel Test Vector Source

This block feeds parallel test vectors to a combinational circuit under test. One linear feedback shift register serves both test phases. After a start request it first runs a pseudorandom stretch, in which the raw register word is the vector. It then runs a deterministic stretch, in which a fixed combinational decoder turns each register word into a stored test vector.

Most decoder outputs are straight or inverted copies of register bits. These are the columns that match. Only the unmatched columns need gates. A phase controller counts the cycles of each stretch, and an output switch picks the source of the vector bus. The two stretch lengths are separate parameters.

Top module: `mm_bist_gen`

## Requirements
- R1: While reset is held and after it is released with no start, `valid_o` and `done_o` are 0 and `vec_o` is all zeros.
- R2: A high `start_i` sampled at a clock edge while idle makes `valid_o` rise right after that edge. The first vector is the seed value SEED (default 8'h01).
- R3: The register state s moves to {s[W-2:0], ^(s & TAPS)} once per valid cycle (default taps 8'hB8, bits 7,5,4,3). It is never zero. It is not reloaded between the phases, and only reset loads SEED.
- R4: The first PR_LEN valid vectors are the raw register words s0, s1, …, where s0 = SEED.
- R5: The next DET_LEN valid vectors are the decoded words y of the register state x. The decoder gives y0=x0, y1=x1, y2=~x2, y3=x1, y4=~x0|x1, and y[i]=~x[i] for i ≥ 5.
- R6: The source switches at the clock edge after the last pseudorandom vector. The first decoded vector is built from register state s[PR_LEN], so no state is skipped or repeated.
- R7: Exactly PR_LEN+DET_LEN consecutive valid cycles occur. After them `valid_o` is 0, `done_o` is 1, and `vec_o` is zero, and this holds until reset.
- R8: `start_i` has no effect while a run is in progress or after `done_o` is set.
- R9: PR_LEN and DET_LEN are independent parameters, each at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a test run when idle |
| vec_o | output | W | Test vector to the circuit under test |
| valid_o | output | 1 | Vector on `vec_o` is a test vector |
| done_o | output | 1 | Both phases complete |

## Verification
The outputs are decoded from state registers with no extra stage. The k-th vector of a run (counting from 0) is therefore present during the k-th cycle after the edge that samples `start_i`. `done_o` appears in the cycle after the last vector. The bench drives inputs and samples outputs at the falling edge. It advances its own register model once per sampled valid cycle, so each comparison falls in the cycle where that result is due. After a run, the bench keeps sampling for several cycles while toggling `start_i`. This shows that `done_o`, `valid_o` and `vec_o` stay unchanged.

// File: rtl/mm_bist_pkg.sv
package mm_bist_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRND = 2'd1,
    PH_DET  = 2'd2,
    PH_DONE = 2'd3
  } phase_e;
endpackage

// File: rtl/mm_bist_lfsr.sv
module mm_bist_lfsr #(
  parameter int unsigned        W    = 8,
  parameter logic [W-1:0]       TAPS = 8'hB8,
  parameter logic [W-1:0]       SEED = 8'h01
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] s_q;
  logic         fb;

  assign fb = ^(s_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     s_q <= SEED;
    else if (step_i) s_q <= {s_q[W-2:0], fb};
  end

  assign state_o = s_q;
endmodule

// File: rtl/mm_bist_decoder.sv
module mm_bist_decoder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o
);
  // matched columns: wires; y4 is the only unmatched column
  assign y_o[0] = x_i[0];
  assign y_o[1] = x_i[1];
  assign y_o[2] = ~x_i[2];
  assign y_o[3] = x_i[1];
  assign y_o[4] = ~x_i[0] | x_i[1];

  for (genvar i = 5; i < W; i++) begin : g_inv
    assign y_o[i] = ~x_i[i];
  end

  logic unused_x3_4;
  assign unused_x3_4 = ^x_i[4:3];
endmodule

// File: rtl/mm_bist_ctrl.sv
module mm_bist_ctrl
  import mm_bist_pkg::*;
#(
  parameter int unsigned PR_LEN  = 16,
  parameter int unsigned DET_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic run_o,
  output logic det_o,
  output logic done_o
);
  localparam int unsigned MAX_LEN = (PR_LEN > DET_LEN) ? PR_LEN : DET_LEN;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  phase_e             ph_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q  <= PH_PRND;
          cnt_q <= '0;
        end
        PH_PRND: if (cnt_q == CNT_W'(PR_LEN - 1)) begin
          ph_q  <= PH_DET;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        PH_DET: if (cnt_q == CNT_W'(DET_LEN - 1)) begin
          ph_q  <= PH_DONE;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: ph_q <= PH_DONE;
      endcase
    end
  end

  assign run_o  = (ph_q == PH_PRND) || (ph_q == PH_DET);
  assign det_o  = (ph_q == PH_DET);
  assign done_o = (ph_q == PH_DONE);
endmodule

// File: rtl/mm_bist_gen.sv
module mm_bist_gen #(
  parameter int unsigned  W       = 8,
  parameter logic [W-1:0] TAPS    = 8'hB8,
  parameter logic [W-1:0] SEED    = 8'h01,
  parameter int unsigned  PR_LEN  = 16,
  parameter int unsigned  DET_LEN = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  output logic [W-1:0] vec_o,
  output logic         valid_o,
  output logic         done_o
);
  logic         run, det_sel;
  logic [W-1:0] lfsr_q, dec_y;

  mm_bist_ctrl #(.PR_LEN(PR_LEN), .DET_LEN(DET_LEN)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .run_o   (run),
    .det_o   (det_sel),
    .done_o  (done_o)
  );

  mm_bist_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (run),
    .state_o (lfsr_q)
  );

  mm_bist_decoder #(.W(W)) u_dec (
    .x_i (lfsr_q),
    .y_o (dec_y)
  );

  // output switch
  always_comb begin
    if (!run)        vec_o = '0;
    else if (det_sel) vec_o = dec_y;
    else              vec_o = lfsr_q;
  end

  assign valid_o = run;
endmodule

// File: rtl/mm_bist_chk.sv
module mm_bist_chk #(
  parameter int unsigned W       = 8,
  parameter int unsigned PR_LEN  = 16,
  parameter int unsigned DET_LEN = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [W-1:0] vec_o,
  input logic         valid_o,
  input logic         done_o,
  input logic [W-1:0] lfsr_q,
  input logic         det_sel
);
  localparam int unsigned TOTAL = PR_LEN + DET_LEN;
  localparam int unsigned VC_W  = $clog2(TOTAL + 1);

  logic [VC_W-1:0] vcnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vcnt_q <= '0;
    else if (valid_o) vcnt_q <= vcnt_q + 1'b1;
    else              vcnt_q <= '0;
  end

  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> vec_o == '0);
  a_r2_start_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !valid_o && !done_o) |=> valid_o);
  a_r3_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
  a_r3_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> lfsr_q != $past(lfsr_q));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |=> $stable(lfsr_q));
  a_r4_raw_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !det_sel) |-> vec_o == lfsr_q);
  a_r5_matched_cols: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && det_sel) |-> (vec_o[3] == lfsr_q[1] && vec_o[2] == !lfsr_q[2]));
  a_r7_valid_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> vcnt_q < VC_W'(TOTAL));
  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && !valid_o);
  a_r7_end_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> done_o);
  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);
endmodule

bind mm_bist_gen mm_bist_chk #(.W(W), .PR_LEN(PR_LEN), .DET_LEN(DET_LEN)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .vec_o   (vec_o),
  .valid_o (valid_o),
  .done_o  (done_o),
  .lfsr_q  (lfsr_q),
  .det_sel (det_sel)
);

// File: tb/mm_bist_gen_test.sv
module mm_bist_gen_test;
  localparam int          CLK_PERIOD = 10;
  localparam int          W          = 8;
  localparam logic [7:0]  TAPS       = 8'hB8;
  localparam logic [7:0]  SEED       = 8'h01;
  localparam int          PR_LEN     = 5;   // R9: non-default, unequal lengths
  localparam int          DET_LEN    = 9;

  logic         clk = 0;
  logic         rst_ni = 0;
  logic         start_i = 0;
  logic [W-1:0] vec_o;
  logic         valid_o, done_o;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_bist_gen #(.W(W), .TAPS(TAPS), .SEED(SEED), .PR_LEN(PR_LEN), .DET_LEN(DET_LEN)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .vec_o(vec_o), .valid_o(valid_o), .done_o(done_o));

  function automatic logic [W-1:0] nxt(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  function automatic logic [W-1:0] dec(input logic [W-1:0] x);
    logic [W-1:0] y;
    y = ~x;                 // upper columns inverted
    y[0] = x[0];
    y[1] = x[1];
    y[2] = ~x[2];
    y[3] = x[1];
    y[4] = ~x[0] | x[1];
    return y;
  endfunction

  task automatic chk(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; start_i = 0;
    @(negedge clk);
    chk("R1", {valid_o, done_o, vec_o}, '0);
    @(negedge clk);
    rst_ni = 1;
  endtask

  // one full run; if rnd_start, start_i toggles randomly during and after (R8)
  task automatic run(input int idle, input bit rnd_start);
    logic [W-1:0] s = SEED;
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      chk("R1", {valid_o, done_o, vec_o}, '0);
    end
    start_i = 1;                          // sampled at next posedge
    for (int k = 0; k < PR_LEN + DET_LEN; k++) begin
      @(negedge clk);
      start_i = rnd_start ? 1'($urandom_range(0, 1)) : 1'b0;
      if (k == 0) chk("R2", {valid_o, done_o, vec_o}, {2'b10, SEED});
      else if (k < PR_LEN)
        chk("R4 R3", {valid_o, done_o, vec_o}, {2'b10, s});
      else if (k == PR_LEN)
        chk("R6 R5", {valid_o, done_o, vec_o}, {2'b10, dec(s)});
      else
        chk("R5 R3", {valid_o, done_o, vec_o}, {2'b10, dec(s)});
      s = nxt(s);
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      start_i = rnd_start ? 1'($urandom_range(0, 1)) : 1'b1;
      chk("R7 R8", {valid_o, done_o, vec_o}, {2'b01, {W{1'b0}}});
    end
    start_i = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    do_reset();
    run(0, 1'b0);                         // directed: start right after reset
    do_reset();                           // R3: only reset reloads seed
    run(3, 1'b1);
    for (int r = 0; r < 6; r++) begin
      do_reset();
      run($urandom_range(0, 7), 1'b1);
    end
    // reset mid-run, then a clean run from seed
    do_reset();
    start_i = 1;
    repeat (4) @(negedge clk);
    do_reset();
    run(1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule